// File: doc/BRIEF.md
# Programmable Slow-Idle Clock Controller

This block sits beside a processor core's sequencer and decides, cycle by cycle, whether the core and its derived clock domains advance. The four domains are the core clock, the serial clock, the clock output and the timer. The controller does not gate any clocks itself. It drives clock enables: the core domain and the serial-clock, clock-output and timer domains each get one.

An idle request can come with a divisor code or without one. Without a code, the block enters standard idle: all enables stay at full rate while the core waits. With a code, it enters slow idle, and all four enables then pulse once every n cycles. The value of n is 16, 32, 64 or 128. Any enabled interrupt ends idle. In slow idle, the exit waits for the next divided pulse. A one-cycle resume pulse then tells the sequencer to move on to the instruction after the idle instruction.

DMA cycle-steal requests are still granted during either kind of idle. A separate power-down request stops all enables and raises an acknowledge. Only reset ends power-down.

Top module: `slow_idle_clkctl`

## Requirements
- R1: After reset the block is running: all four enables are 1, `in_idle`, `resume` and `pd_ack` are 0.
- R2: An idle request with `div_valid`=0 enters standard idle. While it lasts, all four enables stay 1 on every cycle.
- R3: An idle request with `div_valid`=1 enters slow idle. n is 16, 32, 64 or 128 for `div_sel` = 00, 01, 10 or 11. Counting the first idle cycle as 0, all four enables are 1 exactly on cycles that are multiples of n.
- R4: Interrupts whose `irq_en` bit is 0 never end idle. Idle lasts with no time limit until an enabled interrupt arrives.
- R5: In standard idle, an enabled interrupt present in one cycle gives `resume`=1 and `in_idle`=0 in the next cycle.
- R6: In slow idle, exit happens only at a divided pulse. An enabled interrupt first seen in idle cycle k gives `resume` in cycle m+1, where m is the first multiple of n that is at least k. The latency is therefore at most n cycles.
- R7: An enabled interrupt lasting a single cycle is latched and still causes a wake at the next divided pulse.
- R8: `resume` is a single-cycle pulse, and it occurs only when the block leaves idle.
- R9: `dma_gnt` follows `dma_req` in the same cycle while running or idle. It is 0 during power-down.
- R10: A power-down request while running drives all enables to 0 and `pd_ack` to 1 from the next cycle. Only reset leaves power-down.
- R11: Idle and power-down requests are ignored while the block is already idle or powered down. `pd_ack` wins when both requests arrive together while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate processor clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | Request to enter idle (one cycle) |
| div_valid | input | 1 | 1 selects slow idle with `div_sel` |
| div_sel | input | 2 | Divisor code: 00=16, 01=32, 10=64, 11=128 |
| pd_req | input | 1 | Request to enter power-down |
| irq | input | IRQS | Interrupt request lines |
| irq_en | input | IRQS | Per-line enable, 1 = unmasked |
| dma_req | input | 1 | DMA cycle-steal request |
| dma_gnt | output | 1 | DMA cycle-steal grant |
| core_ce | output | 1 | Core clock enable |
| sclk_ce | output | 1 | Serial clock enable |
| clkout_ce | output | 1 | Clock output enable |
| timer_ce | output | 1 | Timer clock enable |
| in_idle | output | 1 | High while idle (either kind) |
| resume | output | 1 | One-cycle pulse on leaving idle |
| pd_ack | output | 1 | Power-down acknowledge |

## Verification
Some properties can be checked on every cycle. The assertions cover these: full-rate enables in standard idle, no exit when no enabled interrupt is pending, a one-cycle response in standard idle, exits landing only on divided pulses, resume being a single pulse, DMA grants while idle, and power-down holding until reset. Other behaviour only the scenarios can show. These cover the exact enable spacing for each divisor code, the precise wake cycle after an interrupt at a chosen divider phase, and a short interrupt pulse being remembered. They also cover requests being ignored in low-power states and reset ending power-down.

// File: rtl/slow_idle_clkctl.sv
module slow_idle_clkctl #(
  parameter int IRQS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            idle_req,
  input  logic            div_valid,
  input  logic [1:0]      div_sel,
  input  logic            pd_req,
  input  logic [IRQS-1:0] irq,
  input  logic [IRQS-1:0] irq_en,
  input  logic            dma_req,
  output logic            dma_gnt,
  output logic            core_ce,
  output logic            sclk_ce,
  output logic            clkout_ce,
  output logic            timer_ce,
  output logic            in_idle,
  output logic            resume,
  output logic            pd_ack
);
  localparam int MIN_LOG = 4;
  localparam int CNT_W   = MIN_LOG + 3;

  typedef enum logic [1:0] {ST_RUN, ST_IDLE, ST_PDOWN} st_t;

  st_t             st;
  logic            slow;
  logic [1:0]      code;
  logic [CNT_W-1:0] cnt;
  logic            pend;
  logic            resume_q;

  wire              irq_hit = |(irq & irq_en);
  wire [CNT_W-1:0]  lowmask = CNT_W'((32'd1 << (MIN_LOG + int'(code))) - 32'd1);
  wire              tick    = !slow || ((cnt & lowmask) == '0);
  wire              wake    = (st == ST_IDLE) && (pend || irq_hit) && tick;
  wire              ce_all  = (st == ST_RUN) || ((st == ST_IDLE) && tick);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      slow     <= 1'b0;
      code     <= '0;
      cnt      <= '0;
      pend     <= 1'b0;
      resume_q <= 1'b0;
    end else begin
      resume_q <= 1'b0;
      case (st)
        ST_RUN: begin
          if (pd_req) begin
            st <= ST_PDOWN;
          end else if (idle_req) begin
            st   <= ST_IDLE;
            slow <= div_valid;
            code <= div_sel;
            cnt  <= '0;
            pend <= 1'b0;
          end
        end
        ST_IDLE: begin
          cnt <= cnt + 1'b1;
          if (wake) begin
            st       <= ST_RUN;
            resume_q <= 1'b1;
            pend     <= 1'b0;
            slow     <= 1'b0;
          end else if (irq_hit) begin
            pend <= 1'b1;
          end
        end
        ST_PDOWN: ;
        default: st <= ST_RUN;
      endcase
    end
  end

  assign core_ce   = ce_all;
  assign sclk_ce   = ce_all;
  assign clkout_ce = ce_all;
  assign timer_ce  = ce_all;
  assign in_idle   = (st == ST_IDLE);
  assign pd_ack    = (st == ST_PDOWN);
  assign resume    = resume_q;
  assign dma_gnt   = dma_req && (st != ST_PDOWN);

  a_r2_std_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !slow) |-> (core_ce && sclk_ce && clkout_ce && timer_ce));

  a_r4_no_wake_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !pend && !irq_hit) |=> (st == ST_IDLE));

  a_r5_std_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && !slow && irq_hit) |=> (resume && st == ST_RUN));

  a_r6_wake_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && $past(st) == ST_IDLE) |-> $past(core_ce));

  a_r8_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);

  a_r9_dma_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && dma_req) |-> dma_gnt);

  a_r10_pd_holds: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack |=> (pd_ack && !core_ce && !in_idle));
endmodule

// File: tb/slow_idle_clkctl_test.sv
module slow_idle_clkctl_test;
  localparam int CLK_PER = 10;
  localparam int IRQS = 4;

  logic clk = 0, rst_n = 0;
  logic idle_req = 0, div_valid = 0, pd_req = 0, dma_req = 0;
  logic [1:0] div_sel = 0;
  logic [IRQS-1:0] irq = 0, irq_en = 0;
  logic dma_gnt, core_ce, sclk_ce, clkout_ce, timer_ce, in_idle, resume, pd_ack;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  slow_idle_clkctl #(.IRQS(IRQS)) uut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .div_valid(div_valid),
    .div_sel(div_sel), .pd_req(pd_req), .irq(irq), .irq_en(irq_en),
    .dma_req(dma_req), .dma_gnt(dma_gnt), .core_ce(core_ce), .sclk_ce(sclk_ce),
    .clkout_ce(clkout_ce), .timer_ce(timer_ce), .in_idle(in_idle),
    .resume(resume), .pd_ack(pd_ack));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  function automatic logic [3:0] ces();
    return {core_ce, sclk_ce, clkout_ce, timer_ce};
  endfunction

  task automatic do_reset();
    rst_n = 0; idle_req = 0; pd_req = 0; irq = 0; irq_en = 0; dma_req = 0;
    step(); step(); rst_n = 1; step();
  endtask

  task automatic enter_idle(input logic sl, input logic [1:0] code);
    idle_req = 1; div_valid = sl; div_sel = code;
    step();
    idle_req = 0; div_valid = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 enables", ces(), 4'hf);
    chk("R1 flags", {in_idle, resume, pd_ack}, 3'b000);
  endtask

  task automatic t_std_idle();
    enter_idle(0, 2'b00);
    chk("R2 in_idle", in_idle, 1);
    irq_en = 4'b0001; irq = 4'b0010;
    for (int i = 0; i < 20; i++) begin
      step();
      chk("R2 full rate", ces(), 4'hf);
      chk("R4 masked stays idle", in_idle, 1);
      chk("R8 no resume", resume, 0);
    end
    irq = 4'b0001;
    step();
    irq = 0;
    chk("R5 resume", resume, 1);
    chk("R5 left idle", in_idle, 0);
    step();
    chk("R8 resume single", resume, 0);
  endtask

  task automatic t_slow(input logic [1:0] code, input int k_irq, input bit short_pulse);
    int n = 16 << code;
    int k = 0;
    int wake_k = -1;
    int m;
    enter_idle(1, code);
    irq_en = 4'b1000;
    while (k < 400 && wake_k < 0) begin
      if (in_idle) chk("R3 ce spacing", ces(), ((k % n) == 0) ? 4'hf : 4'h0);
      if (resume) wake_k = k;
      if (k == k_irq) irq = 4'b1000;
      else if (short_pulse || k < k_irq) irq = 0;
      step(); k++;
    end
    irq = 0;
    m = ((k_irq + n - 1) / n) * n;
    chk(short_pulse ? "R7 latched wake" : "R6 wake cycle", wake_k, m + 1);
    chk("R6 left idle", in_idle, 0);
    chk("R1 full rate after wake", ces(), 4'hf);
  endtask

  task automatic t_dma();
    enter_idle(1, 2'b01);
    dma_req = 1;
    step();
    chk("R9 grant idle", dma_gnt, 1);
    chk("R9 still idle", in_idle, 1);
    dma_req = 0;
    step();
    chk("R9 no req", dma_gnt, 0);
    pd_req = 1; step(); pd_req = 0; step();
    chk("R11 pd ignored in idle", pd_ack, 0);
    idle_req = 1; div_valid = 0; step(); idle_req = 0;
    chk("R11 idle req ignored keeps slow", ces() == 4'hf && in_idle, 0);
    irq_en = 4'b0001; irq = 4'b0001;
    for (int i = 0; i < 40 && in_idle; i++) step();
    irq = 0;
    chk("R6 woke", in_idle, 0);
  endtask

  task automatic t_pdown();
    do_reset();
    pd_req = 1; idle_req = 1;
    step();
    pd_req = 0; idle_req = 0;
    chk("R10 ack", pd_ack, 1);
    chk("R11 pd wins", in_idle, 0);
    chk("R10 enables off", ces(), 4'h0);
    dma_req = 1; step();
    chk("R9 no grant in pd", dma_gnt, 0);
    dma_req = 0;
    idle_req = 1; irq_en = 4'hf; irq = 4'hf; step(); idle_req = 0; irq = 0;
    for (int i = 0; i < 5; i++) step();
    chk("R11 idle ignored in pd", in_idle, 0);
    chk("R10 ack holds", pd_ack, 1);
    do_reset();
    chk("R10 reset exits", pd_ack, 0);
    chk("R10 enables back", ces(), 4'hf);
  endtask

  initial begin
    t_reset();
    t_std_idle();
    t_slow(2'b00, 3, 0);
    t_slow(2'b01, 32, 0);
    t_slow(2'b10, 5, 1);
    t_slow(2'b11, 70, 1);
    t_dma();
    t_pdown();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule